// File: doc/BRIEF.md
# Multi-Latency Issue Port with Shared Writeback Collision Guard

This block models a single execution issue port that fronts three pipelined units: an integer unit with a short class and a long class, a SIMD floating-point multiply unit and a SIMD floating-point add unit. No arithmetic is performed. Each accepted operation carries a destination tag that comes back out as a completion event once the unit's fixed latency has elapsed.

The two floating-point units write back over one shared result bus. The two integer classes share a separate integer bus. Before it accepts an operation, the port checks whether the operation's completion cycle is already reserved on its bus. If that slot is taken, it lowers `in_ready`, and the upstream scheduler holds the operation and offers it again later.

A wide-vector mode input turns off the SIMD units on this port, so every floating-point operation is refused. The integer unit keeps working in this mode. Completions go to a reorder-buffer style interface that has one lane per result bus, so an integer completion and a floating-point completion can be reported in the same cycle.

Top module: `issue_port`

## Requirements
- R1: Class code 2'b00 (fast integer) is accepted on the edge where `in_valid` and `in_ready` are both high. Its tag appears on the integer completion lane with valid high in the cycle after the next rising edge, that is, latency 1.
- R2: Class code 2'b01 (long integer: multiply, population count) completes on the integer lane 3 edges after acceptance.
- R3: Class code 2'b10 (FP multiply) completes on the floating-point lane 5 edges after acceptance. When wide mode is off, one can be accepted on every cycle.
- R4: Class code 2'b11 (FP add) completes on the floating-point lane 3 edges after acceptance.
- R5: An FP add offered exactly 2 cycles after an accepted FP multiply sees `in_ready` low, because both would complete on the same edge. It is accepted one cycle later.
- R6: A fast integer operation offered exactly 2 cycles after an accepted long integer operation sees `in_ready` low.
- R7: While `wide_mode` is high, `in_ready` is low for both FP classes. Both integer classes are still accepted when their bus slot is free.
- R8: `in_ready` is high whenever the offered class is allowed and its completion slot is free. `in_ready` depends only on the offered class, the mode and the reservations. It does not depend on `in_valid`.
- R9: A synchronous active-high reset discards all reservations and in-flight operations. Both completion lanes are low in the cycle after any reset edge.
- R10: When `in_valid` is low, nothing is accepted and no completion results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_class | input | 2 | Class code: 00 fast int, 01 long int, 10 FP mul, 11 FP add |
| in_tag | input | TAG_W | Destination tag of the offered operation |
| wide_mode | input | 1 | Disables the SIMD units on this port |
| in_ready | output | 1 | The offered operation may start this cycle |
| int_cpl_valid | output | 1 | Integer lane completion event |
| int_cpl_tag | output | TAG_W | Tag of the completing integer operation |
| fp_cpl_valid | output | 1 | Floating-point lane completion event |
| fp_cpl_tag | output | TAG_W | Tag of the completing floating-point operation |

## Verification
`in_ready` is combinational, so it is due in the same cycle the operation is offered. A completion is due exactly L rising edges after the accepting edge, where L is 1, 3, 5 or 3 depending on the class. The bench numbers every rising edge. When it accepts an operation on edge n, it books the expected tag for edge n+L in a per-bus associative array. Just after each falling edge it compares both lanes against the booking for the current edge number. It then drives the next offer and compares `in_ready`, allowing 1 time unit for it to settle, against its own refusal rule. Directed sequences hit the refusal distances exactly, and they are followed by a long held-and-retried random stream that includes wide-mode phases and a reset with operations in flight.

// File: rtl/issue_port_pkg.sv
package issue_port_pkg;

  typedef enum logic [1:0] {
    CLS_INT_FAST = 2'b00,
    CLS_INT_LONG = 2'b01,
    CLS_FP_MUL   = 2'b10,
    CLS_FP_ADD   = 2'b11
  } op_class_e;

  localparam int LAT_INT_FAST = 1;
  localparam int LAT_INT_LONG = 3;
  localparam int LAT_FP_MUL   = 5;
  localparam int LAT_FP_ADD   = 3;
  localparam int MAX_LAT      = 5;
  localparam int RESV_DEPTH   = MAX_LAT + 1;
  localparam int LAT_W        = $clog2(RESV_DEPTH);
  localparam int NUM_BUS      = 2;
  localparam int BUS_INT      = 0;
  localparam int BUS_FP       = 1;

  function automatic logic [LAT_W-1:0] op_latency(input op_class_e c);
    case (c)
      CLS_INT_FAST: return LAT_W'(LAT_INT_FAST);
      CLS_INT_LONG: return LAT_W'(LAT_INT_LONG);
      CLS_FP_MUL:   return LAT_W'(LAT_FP_MUL);
      default:      return LAT_W'(LAT_FP_ADD);
    endcase
  endfunction

  function automatic logic op_is_fp(input op_class_e c);
    return (c == CLS_FP_MUL) || (c == CLS_FP_ADD);
  endfunction

endpackage

// File: rtl/wb_resv_lane.sv
module wb_resv_lane
  import issue_port_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DEPTH = RESV_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [LAT_W-1:0] issue_lat,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             slot_taken,
  output logic             cpl_valid,
  output logic [TAG_W-1:0] cpl_tag
);

  logic [DEPTH-1:0] pend_v;
  logic [TAG_W-1:0] pend_t [DEPTH];

  // Slot that will hold an op of latency issue_lat after this edge's shift
  always_comb begin
    slot_taken = 1'b0;
    for (int j = 1; j < DEPTH; j++) begin
      if (j == int'(issue_lat) + 1) slot_taken = pend_v[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= '0;
      for (int j = 0; j < DEPTH; j++) pend_t[j] <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) begin
        if (issue && j == int'(issue_lat)) begin
          pend_v[j] <= 1'b1;
          pend_t[j] <= issue_tag;
        end else if (j < DEPTH - 1) begin
          pend_v[j] <= pend_v[j+1];
          pend_t[j] <= pend_t[j+1];
        end else begin
          pend_v[j] <= 1'b0;
          pend_t[j] <= '0;
        end
      end
    end
  end

  assign cpl_valid = pend_v[0];
  assign cpl_tag   = pend_t[0];

  // R5
  issue_free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !slot_taken);

  // R9
  post_reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !cpl_valid);

endmodule

// File: rtl/issue_port.sv
module issue_port
  import issue_port_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_class,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             wide_mode,
  output logic             in_ready,
  output logic             int_cpl_valid,
  output logic [TAG_W-1:0] int_cpl_tag,
  output logic             fp_cpl_valid,
  output logic [TAG_W-1:0] fp_cpl_tag
);

  op_class_e        cls;
  logic [LAT_W-1:0] lat;
  logic             is_fp;
  logic             fp_blocked;
  logic             conflict;
  logic             accept;
  logic [NUM_BUS-1:0] taken;
  logic [NUM_BUS-1:0] bus_issue;
  logic [NUM_BUS-1:0] bus_cpl_v;
  logic [TAG_W-1:0]   bus_cpl_t [NUM_BUS];

  assign cls        = op_class_e'(in_class);
  assign lat        = op_latency(cls);
  assign is_fp      = op_is_fp(cls);
  assign fp_blocked = wide_mode && is_fp;
  assign conflict   = is_fp ? taken[BUS_FP] : taken[BUS_INT];
  assign in_ready   = !fp_blocked && !conflict;
  assign accept     = in_valid && in_ready;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    assign bus_issue[b] = accept && (is_fp == (b == BUS_FP));
    wb_resv_lane #(.TAG_W(TAG_W), .DEPTH(RESV_DEPTH)) u_lane (
      .clk(clk), .rst(rst),
      .issue(bus_issue[b]), .issue_lat(lat), .issue_tag(in_tag),
      .slot_taken(taken[b]),
      .cpl_valid(bus_cpl_v[b]), .cpl_tag(bus_cpl_t[b])
    );
  end

  assign int_cpl_valid = bus_cpl_v[BUS_INT];
  assign int_cpl_tag   = bus_cpl_t[BUS_INT];
  assign fp_cpl_valid  = bus_cpl_v[BUS_FP];
  assign fp_cpl_tag    = bus_cpl_t[BUS_FP];

  // R7
  wide_blocks_fp_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_mode && is_fp) |-> !in_ready);

  // R3
  fmul_streams_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && cls == CLS_FP_MUL) |=> (cls != CLS_FP_MUL || wide_mode || in_ready));

  // R10
  idle_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (bus_issue == '0));

endmodule

// File: tb/issue_port_tb.sv
module issue_port_tb;
  localparam int PERIOD = 10;
  localparam int TAG_W  = 6;

  logic clk = 0, rst = 1, in_valid = 0, wide_mode = 0;
  logic [1:0] in_class = 0;
  logic [TAG_W-1:0] in_tag = 0;
  logic in_ready, int_cpl_valid, fp_cpl_valid;
  logic [TAG_W-1:0] int_cpl_tag, fp_cpl_tag;

  issue_port #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_tag(in_tag), .wide_mode(wide_mode), .in_ready(in_ready),
    .int_cpl_valid(int_cpl_valid), .int_cpl_tag(int_cpl_tag),
    .fp_cpl_valid(fp_cpl_valid), .fp_cpl_tag(fp_cpl_tag));

  always #(PERIOD/2) clk = ~clk;

  int edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_int [int];
  int exp_fp  [int];
  bit rst_seen = 0;

  function automatic int lat_of(input int c);
    if (c == 0) return 1;
    if (c == 1) return 3;
    if (c == 2) return 5;
    return 3;
  endfunction

  function automatic string req_of(input int c);
    if (c == 0) return "R1";
    if (c == 1) return "R2";
    if (c == 2) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // Called just after a falling edge: compare both lanes for current edge
  task automatic check_lanes();
    int now = edge_n;
    string r;
    if (exp_int.exists(now)) begin
      r = req_of(exp_int[now] / 256);
      chk(int_cpl_valid == 1, r, "int valid", int_cpl_valid, 1);
      chk(int'(int_cpl_tag) == exp_int[now] % 256, r, "int tag", int_cpl_tag, exp_int[now] % 256);
      exp_int.delete(now);
    end else begin
      r = rst_seen ? "R9" : "R10";
      chk(int_cpl_valid == 0, r, "int idle", int_cpl_valid, 0);
    end
    if (exp_fp.exists(now)) begin
      r = req_of(exp_fp[now] / 256);
      chk(fp_cpl_valid == 1, r, "fp valid", fp_cpl_valid, 1);
      chk(int'(fp_cpl_tag) == exp_fp[now] % 256, r, "fp tag", fp_cpl_tag, exp_fp[now] % 256);
      exp_fp.delete(now);
    end else begin
      r = rst_seen ? "R9" : "R10";
      chk(fp_cpl_valid == 0, r, "fp idle", fp_cpl_valid, 0);
    end
    rst_seen = 0;
  endtask

  // One cycle: check lanes, drive offer, check ready, model acceptance
  task automatic cycle(input bit v, input int c, input int tag, input bit wide, output bit acc);
    bit fp, exp_rdy, clash;
    int due;
    string r;
    @(negedge clk);
    check_lanes();
    in_valid = v; in_class = 2'(c); in_tag = TAG_W'(tag); wide_mode = wide;
    #1;
    fp = (c >= 2);
    due = edge_n + 1 + lat_of(c);
    clash = fp ? exp_fp.exists(due) : exp_int.exists(due);
    exp_rdy = !(wide && fp) && !clash;
    if (wide && fp) r = "R7";
    else if (clash) r = fp ? "R5" : "R6";
    else r = (wide ? "R7" : (c == 2 ? "R3" : "R8"));
    chk(in_ready == exp_rdy, r, "in_ready", in_ready, exp_rdy);
    acc = v && exp_rdy;
    if (acc) begin
      if (fp) exp_fp[due] = c * 256 + tag;
      else    exp_int[due] = c * 256 + tag;
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (n) @(negedge clk);
    rst = 0;
    exp_int.delete(); exp_fp.delete();
    rst_seen = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit a;
    int c, tag, hold_c, hold_tag;
    bit holding, wide;
    do_reset(3);
    // R9: reset state, ready for any class right after reset
    cycle(0, 0, 0, 0, a);
    // R1 fast int
    cycle(1, 0, 5, 0, a);
    cycle(0, 0, 0, 0, a);
    // R2 then R6: long int, idle, fast int refused, retry accepted
    cycle(1, 1, 7, 0, a);
    cycle(0, 0, 0, 0, a);
    cycle(1, 0, 8, 0, a);
    chk(a == 0, "R6", "refused fast int", a, 0);
    cycle(1, 0, 8, 0, a);
    chk(a == 1, "R6", "retry accepted", a, 1);
    repeat (4) cycle(0, 0, 0, 0, a);
    // R3 then R5: mul, idle, add refused, retry accepted
    cycle(1, 2, 11, 0, a);
    cycle(0, 0, 0, 0, a);
    cycle(1, 3, 12, 0, a);
    chk(a == 0, "R5", "refused fp add", a, 0);
    cycle(1, 3, 12, 0, a);
    chk(a == 1, "R5", "add retry accepted", a, 1);
    repeat (6) cycle(0, 0, 0, 0, a);
    // R3 back-to-back multiplies
    for (int i = 0; i < 6; i++) begin
      cycle(1, 2, 20 + i, 0, a);
      chk(a == 1, "R3", "mul stream", a, 1);
    end
    // R4 add alone
    repeat (6) cycle(0, 0, 0, 0, a);
    cycle(1, 3, 30, 0, a);
    // R7 wide mode: fp refused, int accepted
    cycle(1, 2, 31, 1, a);
    chk(a == 0, "R7", "wide mul refused", a, 0);
    cycle(1, 3, 32, 1, a);
    chk(a == 0, "R7", "wide add refused", a, 0);
    cycle(1, 1, 33, 1, a);
    chk(a == 1, "R7", "wide long int", a, 1);
    cycle(1, 0, 34, 1, a);
    chk(a == 1, "R7", "wide fast int", a, 1);
    repeat (6) cycle(0, 0, 0, 0, a);
    // R9: reset with ops in flight
    cycle(1, 2, 40, 0, a);
    cycle(1, 1, 41, 0, a);
    do_reset(1);
    repeat (7) cycle(0, 0, 0, 0, a);
    // Random held/retried stream
    holding = 0; hold_c = 0; hold_tag = 0;
    for (int i = 0; i < 4000; i++) begin
      wide = ((i / 300) % 3 == 2);
      if (!holding) begin
        hold_c = int'($urandom_range(3));
        hold_tag = int'($urandom_range(63));
      end
      if ($urandom_range(3) != 0) begin
        cycle(1, hold_c, hold_tag, wide, a);
        holding = !a && !(wide && hold_c >= 2);
      end else begin
        cycle(0, hold_c, hold_tag, wide, a);
        holding = 1;
      end
      if (i == 2500) do_reset(2);
    end
    repeat (8) cycle(0, 0, 0, 0, a);
    finish_run();
  end
endmodule